// File: doc/BRIEF.md
# Three-Share Masked Bitwise AND

This block computes the bitwise AND of two secret words without ever recombining either secret. Each operand arrives as three Boolean shares: a syndrome word and a key word. The result leaves as three Boolean shares whose exclusive-OR equals the AND of the two secrets. Three separate share functions build the result. Each function sees only two of the three shares of either secret, so no single function can observe a secret in full.

One word is accepted on every clock in which the valid strobe is high. The three result shares are registered, and they appear one cycle after the word is accepted. The result shares are kept uniform by a refresh. The refresh draws only two fresh random bits per word. The remaining refresh bits are the second and third key shares shifted up by one position. The bit pushed out of the top of each of those shares is kept and serves as the fresh bit for the next word. A start pulse seeds those two carried bits from an external random input at the beginning of a stream.

Top module: `tri_share_and`

## Requirements
- R1: One cycle after an accepted word (`in_valid_i` high), `q_a_o ^ q_b_o ^ q_c_o` equals `(s_a_i ^ s_b_i ^ s_c_i) & (k_a_i ^ k_b_i ^ k_c_i)` of that word, bit for bit.
- R2: Share A equals `(s_a&k_a) ^ (s_a&k_b) ^ (k_a&s_b) ^ r1`.
- R3: Share B equals `(s_b&k_b) ^ (s_b&k_c) ^ (k_b&s_c) ^ r2`.
- R4: Share C equals `(s_c&k_c) ^ (s_c&k_a) ^ (k_c&s_a) ^ r1 ^ r2`.
- R5: The refresh vectors are `r1 = {k_b[W-2:0], b1}` and `r2 = {k_c[W-2:0], b2}`, so the fresh bit sits at bit 0.
- R6: Without a start pulse, b1 and b2 are bit W-1 of `k_b_i` and of `k_c_i` of the most recently accepted word. Idle cycles leave them unchanged.
- R7: When `start_i` is high, the word accepted in the same cycle uses b1 = `rnd_i[0]` and b2 = `rnd_i[1]`. A start pulse with no word makes those bits the carried values for the next word.
- R8: `q_valid_o` equals `in_valid_i` delayed by exactly one clock.
- R9: In a cycle with no accepted word, all three result shares keep their values.
- R10: While `rst_n` is low, all result shares and `q_valid_o` are zero. The carried refresh bits are cleared, so the first word after reset without a start pulse uses b1 = b2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Seeds the two carried refresh bits from `rnd_i` |
| rnd_i | input | 2 | Fresh random bits; bit 0 feeds b1, bit 1 feeds b2 |
| in_valid_i | input | 1 | A word is presented on the share inputs |
| s_a_i | input | W | Syndrome share A (masked syndrome) |
| s_b_i | input | W | Syndrome share B |
| s_c_i | input | W | Syndrome share C |
| k_a_i | input | W | Key share A (masked key) |
| k_b_i | input | W | Key share B (also source of r1) |
| k_c_i | input | W | Key share C (also source of r2) |
| q_a_o | output | W | Result share A |
| q_b_o | output | W | Result share B |
| q_c_o | output | W | Result share C |
| q_valid_o | output | 1 | Result shares were updated on the last edge |

## Verification
Two functions can act in the same cycle. A start pulse can seed the refresh bits on the same edge that a word is accepted and its top key-share bits are captured as the next carry. The bench provokes this with directed cycles where both strobes are high, and with random streams that scatter start pulses among valid words and idle gaps. A bench-side model of the carried bits predicts each share exactly. A wrong priority between seed and carry therefore shows up in bit 0 of the shares, both for the current word and for the next one.

// File: rtl/tsand_pkg.sv
// Package: shared constants and helpers for the three-share masked AND.
// Assumes share index order A=0, B=1, C=2, cyclic successor used by share functions.
package tsand_pkg;

    localparam int NSHARE = 3;

    typedef enum logic [1:0] {
        SH_A = 2'd0,
        SH_B = 2'd1,
        SH_C = 2'd2
    } share_idx_e;

    // Cyclic successor of a share index (A->B->C->A).
    function automatic int next_share(input int idx);
        return (idx + 1) % NSHARE;
    endfunction

endpackage

// File: rtl/tsand_share_fn.sv
// Module: one output share function of the masked AND, with its own output register.
// Computes own&own ^ own_s&next_k ^ own_k&next_s ^ mask and registers it on enable.
// Assumes: it is fed only the "own" and "next" shares of each secret (non-completeness).
module tsand_share_fn #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] s_own_i,
    input  logic [W-1:0] s_nxt_i,
    input  logic [W-1:0] k_own_i,
    input  logic [W-1:0] k_nxt_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] y_o
);

    logic [W-1:0] cross_w;

    // Cross-product terms of this share, refreshed by the mask.
    always_comb begin
        cross_w = (s_own_i & k_own_i) ^ (s_own_i & k_nxt_i) ^ (k_own_i & s_nxt_i) ^ mask_i;
    end

    // Register the share so glitches never meet other shares combinationally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o <= '0;
        end else if (en_i) begin
            y_o <= cross_w;
        end
    end

endmodule

// File: rtl/tsand_refresh.sv
// Module: builds the two refresh vectors from shifted key masks plus carried bits.
// r1 = {kb[W-2:0], b1}, r2 = {kc[W-2:0], b2}. The carried bits are the top bits of
// the last accepted kb/kc words; a start pulse overrides them with rnd_i.
// Assumes: start_i and take_i may be high together; start wins for the current word.
module tsand_refresh #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   rnd_i,
    input  logic         take_i,
    input  logic [W-1:0] kb_i,
    input  logic [W-1:0] kc_i,
    output logic [W-1:0] r1_o,
    output logic [W-1:0] r2_o
);

    logic [1:0] carry_q;
    logic [1:0] fresh_w;

    // Pick the fresh bits for the current word: seed on start, else carried bits.
    always_comb begin
        fresh_w = start_i ? rnd_i : carry_q;
        r1_o    = {kb_i[W-2:0], fresh_w[0]};
        r2_o    = {kc_i[W-2:0], fresh_w[1]};
    end

    // Keep the shifted-out top bits for the next word, or the seed when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 2'b00;
        end else if (take_i) begin
            carry_q <= {kc_i[W-1], kb_i[W-1]};
        end else if (start_i) begin
            carry_q <= rnd_i;
        end
    end

endmodule

// File: rtl/tri_share_and.sv
// Module: top of the three-share masked bitwise AND, one W-bit word per clock.
// Three share functions each see two shares of each secret; outputs are refreshed
// and registered, latency one cycle. Assumes inputs are fresh uniform shares.
module tri_share_and #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   rnd_i,
    input  logic         in_valid_i,
    input  logic [W-1:0] s_a_i,
    input  logic [W-1:0] s_b_i,
    input  logic [W-1:0] s_c_i,
    input  logic [W-1:0] k_a_i,
    input  logic [W-1:0] k_b_i,
    input  logic [W-1:0] k_c_i,
    output logic [W-1:0] q_a_o,
    output logic [W-1:0] q_b_o,
    output logic [W-1:0] q_c_o,
    output logic         q_valid_o
);
    import tsand_pkg::*;

    logic [W-1:0] s_sh   [NSHARE];
    logic [W-1:0] k_sh   [NSHARE];
    logic [W-1:0] mask_w [NSHARE];
    logic [W-1:0] y_w    [NSHARE];
    logic [W-1:0] r1_w;
    logic [W-1:0] r2_w;

    // Gather the shares into indexed arrays for the generate loop.
    always_comb begin
        s_sh[SH_A] = s_a_i;
        s_sh[SH_B] = s_b_i;
        s_sh[SH_C] = s_c_i;
        k_sh[SH_A] = k_a_i;
        k_sh[SH_B] = k_b_i;
        k_sh[SH_C] = k_c_i;
    end

    // Assign refresh masks per share: r1, r2 and their sum so the masks cancel.
    always_comb begin
        mask_w[SH_A] = r1_w;
        mask_w[SH_B] = r2_w;
        mask_w[SH_C] = r1_w ^ r2_w;
    end

    tsand_refresh #(.W(W)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .rnd_i   (rnd_i),
        .take_i  (in_valid_i),
        .kb_i    (k_b_i),
        .kc_i    (k_c_i),
        .r1_o    (r1_w),
        .r2_o    (r2_w)
    );

    for (genvar g = 0; g < NSHARE; g++) begin : g_share
        localparam int NX = (g + 1) % NSHARE;
        tsand_share_fn #(.W(W)) u_fn (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (in_valid_i),
            .s_own_i (s_sh[g]),
            .s_nxt_i (s_sh[NX]),
            .k_own_i (k_sh[g]),
            .k_nxt_i (k_sh[NX]),
            .mask_i  (mask_w[g]),
            .y_o     (y_w[g])
        );
    end

    // Drive the output ports from the registered shares.
    always_comb begin
        q_a_o = y_w[SH_A];
        q_b_o = y_w[SH_B];
        q_c_o = y_w[SH_C];
    end

    // Valid flag follows the input strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid_o <= 1'b0;
        end else begin
            q_valid_o <= in_valid_i;
        end
    end

endmodule

// File: rtl/tsand_checker.sv
// Module: temporal checks on the masked AND ports; attached to the top by bind.
// Assumes synchronous active-low reset, all checks disabled while it is low.
module tsand_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         in_valid_i,
    input logic [W-1:0] s_a_i,
    input logic [W-1:0] s_b_i,
    input logic [W-1:0] s_c_i,
    input logic [W-1:0] k_a_i,
    input logic [W-1:0] k_b_i,
    input logic [W-1:0] k_c_i,
    input logic [W-1:0] q_a_o,
    input logic [W-1:0] q_b_o,
    input logic [W-1:0] q_c_o,
    input logic         q_valid_o
);

    // R1: recombined result equals AND of the recombined secrets.
    p_recombine_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> ((q_a_o ^ q_b_o ^ q_c_o) ==
                        $past((s_a_i ^ s_b_i ^ s_c_i) & (k_a_i ^ k_b_i ^ k_c_i))));

    // R2 / R5: upper bits of share A carry the shifted key share B as refresh.
    p_share_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (q_a_o[W-1:1] ==
            $past(((s_a_i & k_a_i) ^ (s_a_i & k_b_i) ^ (k_a_i & s_b_i)) >> 1)
            ^ $past(k_b_i[W-2:0])));

    // R3 / R5: upper bits of share B carry the shifted key share C as refresh.
    p_share_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (q_b_o[W-1:1] ==
            $past(((s_b_i & k_b_i) ^ (s_b_i & k_c_i) ^ (k_b_i & s_c_i)) >> 1)
            ^ $past(k_c_i[W-2:0])));

    // R8: valid output is the input strobe delayed by one clock.
    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_valid_o == $past(in_valid_i)));

    // R9: without an accepted word the shares hold.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(q_a_o) && $stable(q_b_o) && $stable(q_c_o)));

    // R7: a start pulse alone does not disturb the result shares.
    p_start_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !in_valid_i) |=> $stable(q_c_o));

endmodule

bind tri_share_and tsand_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .s_a_i      (s_a_i),
    .s_b_i      (s_b_i),
    .s_c_i      (s_c_i),
    .k_a_i      (k_a_i),
    .k_b_i      (k_b_i),
    .k_c_i      (k_c_i),
    .q_a_o      (q_a_o),
    .q_b_o      (q_b_o),
    .q_c_o      (q_c_o),
    .q_valid_o  (q_valid_o)
);

// File: tb/tri_share_and_bench.sv
// Bench: directed corner cases plus seeded random stream against a bench-side model.
module tri_share_and_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   rnd_i = 2'b00;
    logic         in_valid_i = 1'b0;
    logic [W-1:0] s_a_i = '0, s_b_i = '0, s_c_i = '0;
    logic [W-1:0] k_a_i = '0, k_b_i = '0, k_c_i = '0;
    logic [W-1:0] q_a_o, q_b_o, q_c_o;
    logic         q_valid_o;

    int n_chk = 0;
    int n_fail = 0;
    logic         m_c1 = 1'b0, m_c2 = 1'b0;
    logic [W-1:0] m_a = '0, m_b = '0, m_c = '0;

    always #5 clk = ~clk;

    tri_share_and #(.W(W)) u_tri_share_and (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rnd_i(rnd_i),
        .in_valid_i(in_valid_i),
        .s_a_i(s_a_i), .s_b_i(s_b_i), .s_c_i(s_c_i),
        .k_a_i(k_a_i), .k_b_i(k_b_i), .k_c_i(k_c_i),
        .q_a_o(q_a_o), .q_b_o(q_b_o), .q_c_o(q_c_o), .q_valid_o(q_valid_o)
    );

    function automatic logic [W-1:0] cross3(input logic [W-1:0] so, sn, ko, kn);
        return (so & ko) ^ (so & kn) ^ (ko & sn);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check after the next rising edge.
    task automatic step(input bit v, input bit st, input logic [1:0] rn,
                        input logic [W-1:0] sa, sb, sc, ka, kb, kc);
        logic b1, b2;
        logic [W-1:0] r1, r2, x;
        @(negedge clk);
        in_valid_i = v; start_i = st; rnd_i = rn;
        s_a_i = sa; s_b_i = sb; s_c_i = sc; k_a_i = ka; k_b_i = kb; k_c_i = kc;
        b1 = st ? rn[0] : m_c1;
        b2 = st ? rn[1] : m_c2;
        r1 = {kb[W-2:0], b1};
        r2 = {kc[W-2:0], b2};
        x  = (sa ^ sb ^ sc) & (ka ^ kb ^ kc);
        if (v) begin
            m_a = cross3(sa, sb, ka, kb) ^ r1;
            m_b = cross3(sb, sc, kb, kc) ^ r2;
            m_c = cross3(sc, sa, kc, ka) ^ r1 ^ r2;
            m_c1 = kb[W-1];
            m_c2 = kc[W-1];
        end else if (st) begin
            m_c1 = rn[0];
            m_c2 = rn[1];
        end
        @(posedge clk);
        #1;
        chk("R8 valid", {{(W-1){1'b0}}, q_valid_o}, {{(W-1){1'b0}}, v});
        if (v) begin
            chk(st ? "R2 R5 R7 share A" : "R2 R5 R6 share A", q_a_o, m_a);
            chk(st ? "R3 R5 R7 share B" : "R3 R5 R6 share B", q_b_o, m_b);
            chk("R4 share C", q_c_o, m_c);
            chk("R1 recombine", q_a_o ^ q_b_o ^ q_c_o, x);
        end else begin
            chk("R9 hold A", q_a_o, m_a);
            chk("R9 hold B", q_b_o, m_b);
            chk("R9 hold C", q_c_o, m_c);
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 2'b00, '0, '0, '0, '0, '0, '0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog R8 actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state at the ports
        chk("R10 reset valid", {{(W-1){1'b0}}, q_valid_o}, '0);
        chk("R10 reset A", q_a_o, '0);
        chk("R10 reset B", q_b_o, '0);
        chk("R10 reset C", q_c_o, '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: first word without start uses cleared carry bits
        step(1'b1, 1'b0, 2'b11, 32'h1234_5678, 32'h0F0F_0F0F, 32'hAAAA_5555,
             32'hDEAD_BEEF, 32'h8000_0001, 32'h7FFF_FFFE);
        // R6: carry from previous top bits (k_b[31]=1, k_c[31]=0)
        step(1'b1, 1'b0, 2'b00, 32'hFFFF_FFFF, 32'h0, 32'h0,
             32'hFFFF_FFFF, 32'h0, 32'h0);
        // R7: start and word together, seed wins over carry
        step(1'b1, 1'b1, 2'b10, 32'hCAFE_F00D, 32'h1357_9BDF, 32'h2468_ACE0,
             32'h0000_FFFF, 32'hFFFF_0000, 32'h8000_8000);
        // R6 R9: idle gap keeps carry (k_b[31]=1, k_c[31]=1 above) and shares
        idle(); idle(); idle();
        step(1'b1, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
        // R7: start alone seeds the next word
        step(1'b0, 1'b1, 2'b01, '0, '0, '0, '0, '0, '0);
        idle();
        step(1'b1, 1'b0, 2'b00, 32'h5555_AAAA, 32'h0, 32'h0, 32'h3333_CCCC, 32'h0, 32'h0);
        // R1: all-ones secrets
        step(1'b1, 1'b0, 2'b00, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0);
        // random stream with scattered start pulses and gaps
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, ($urandom % 16) == 0, 2'($urandom),
                 $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
        end
        idle();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule